// File: doc/BRIEF.md
# Byte ALU with Program Status Flags

This block is the arithmetic and logic unit of an accumulator-oriented 8-bit core. Each operation takes the accumulator, a second operand byte, the B register and the incoming carry, auxiliary-carry and overflow flags. It returns a new accumulator byte and updated flags. Multiply and divide also return a byte for B. Most operations settle within the cycle in which they are presented, so the core can write the result back at the next clock edge.

Multiply and divide run under a small state machine. In `MD_IDLE`, a valid multiply or divide request is accepted and moves the machine to `MD_RUN`. The operands are latched and the result is formed at acceptance. `MD_RUN` holds `busy` while a counter runs. When the counter reaches its last value the machine moves to `MD_DONE`. `MD_DONE` presents the stored result with a one-cycle `done` pulse and a write strobe for B, then returns unconditionally to `MD_IDLE`. The whole operation spans `MD_LAT` cycles, counting the accept cycle and the done cycle. Any request presented outside `MD_IDLE` is dropped.

The block has no zero flag; software tests the accumulator value directly. The parity output always reflects the accumulator value currently presented at the input. The flag byte that holds these bits is kept outside the block, in this order from bit 7 down to bit 0: CY, AC, F0, RS1, RS0, OV, a spare user bit, P.

Top module: `byte_alu`

## Requirements
- R1: Add forms A + operand (plus CY for the add-with-carry form). CY takes the carry out of bit 7, AC takes the carry out of bit 3, and OV is set exactly on two's-complement overflow.
- R2: Subtract-with-borrow forms A − operand − CY. CY is set when a borrow leaves bit 7, AC is set when a borrow leaves bit 3, and OV is set on signed overflow.
- R3: Increment and decrement change A by one, wrap between FFh and 00h, and leave CY, AC and OV unchanged.
- R4: AND, OR and XOR combine A with the operand bitwise, clear gives 00h, complement gives the bitwise inverse of A, and none of them changes a flag.
- R5: Rotate left moves bit 7 into bit 0 and rotate right moves bit 0 into bit 7. The through-carry forms shift CY in and move the bit shifted out into CY.
- R6: Swap exchanges the high and low nibbles of A and leaves the flags unchanged.
- R7: Decimal adjust first adds 06h if the low nibble exceeds 9 or AC is set. It then adds 60h and sets CY if the high nibble of that sum exceeds 9, CY was set, or the first step carried out of bit 7. It never clears CY.
- R8: Multiply places the 16-bit product of A and B with the low byte in A and the high byte in B. It clears CY, and sets OV exactly when the product exceeds FFh.
- R9: Divide places the quotient of A/B in A and the remainder in B, and clears CY and OV. A zero divisor sets OV and clears CY.
- R10: Compare treats A and the operand as unsigned and sets CY exactly when A is below the operand. It drives `ne_out` high when they differ, and leaves A, AC and OV unchanged.
- R11: `acc_par` is 1 exactly when `acc_in` holds an odd number of ones.
- R12: An accepted multiply or divide raises `busy` from the next cycle. `done` and `res_b_we` pulse for one cycle, `MD_LAT` cycles after acceptance counting the accept cycle as the first. Requests that arrive while the machine is not idle are ignored.
- R13: After reset, `busy`, `done` and `res_b_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 5 | Operation select (package enumeration) |
| acc_in | input | 8 | Accumulator |
| opd_in | input | 8 | Second operand byte |
| b_in | input | 8 | B register |
| cy_in | input | 1 | Current carry |
| ac_in | input | 1 | Current auxiliary carry |
| ov_in | input | 1 | Current overflow |
| res_a | output | 8 | New accumulator value |
| res_b | output | 8 | New B value (multiply/divide) |
| res_b_we | output | 1 | B write strobe |
| cy_out | output | 1 | New carry |
| ac_out | output | 1 | New auxiliary carry |
| ov_out | output | 1 | New overflow |
| ne_out | output | 1 | Compare inequality |
| acc_par | output | 1 | Parity of accumulator |
| busy | output | 1 | Multiply/divide in progress |
| done | output | 1 | Multiply/divide result pulse |

## Verification
The bench builds the block with its defaults, an 8-bit datapath and a four-cycle multiply/divide latency. At 8 bits, random operands reach every nibble carry, signed-overflow and decimal-adjust case within a few hundred draws. The four-cycle window leaves two cycles between acceptance and the result pulse. The bench injects a competing request in that gap to confirm it is dropped.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUBB = 5'd2,
        OP_INC  = 5'd3,
        OP_DEC  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_CLR  = 5'd8,
        OP_CPL  = 5'd9,
        OP_RL   = 5'd10,
        OP_RLC  = 5'd11,
        OP_RR   = 5'd12,
        OP_RRC  = 5'd13,
        OP_SWAP = 5'd14,
        OP_DADJ = 5'd15,
        OP_MUL  = 5'd16,
        OP_DIV  = 5'd17,
        OP_CMP  = 5'd18
    } alu_op_e;

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_RUN  = 2'd1,
        MD_DONE = 2'd2
    } md_state_e;

    function automatic logic is_multi(input alu_op_e op);
        return (op == OP_MUL) || (op == OP_DIV);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          hcout,
    output logic          ovf
);
    localparam int NW = DW / 2;

    logic [DW-1:0] b_eff;
    logic          c_eff;
    logic [NW:0]   low;
    logic [DW:0]   full;

    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        low   = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};
        full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
        sum   = full[DW-1:0];
        // a borrow is the inverse of the carry of the complemented add
        cout  = sub ? ~full[DW] : full[DW];
        hcout = sub ? ~low[NW]  : low[NW];
        ovf   = (a[DW-1] == b_eff[DW-1]) && (full[DW-1] != a[DW-1]);
    end

endmodule

// File: rtl/alu_bitops.sv
`timescale 1ns/1ps
module alu_bitops import alu_pkg::*; #(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] opd,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cy
);
    localparam int NW = DW / 2;

    always_comb begin
        res = a;
        cy  = cin;
        unique case (op)
            OP_AND:  res = a & opd;
            OP_OR:   res = a | opd;
            OP_XOR:  res = a ^ opd;
            OP_CLR:  res = '0;
            OP_CPL:  res = ~a;
            OP_RL:   res = {a[DW-2:0], a[DW-1]};
            OP_RR:   res = {a[0], a[DW-1:1]};
            OP_RLC: begin
                res = {a[DW-2:0], cin};
                cy  = a[DW-1];
            end
            OP_RRC: begin
                res = {cin, a[DW-1:1]};
                cy  = a[0];
            end
            OP_SWAP: res = {a[NW-1:0], a[DW-1:NW]};
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu_dadj.sv
`timescale 1ns/1ps
module alu_dadj #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic          cin,
    input  logic          hcin,
    output logic [DW-1:0] res,
    output logic          cy
);
    localparam int NW = DW / 2;
    localparam logic [DW-1:0] LOW_FIX  = DW'(6);
    localparam logic [DW-1:0] HIGH_FIX = LOW_FIX << NW;
    localparam logic [NW-1:0] DIGIT_MAX = NW'(9);

    logic        lo_fix;
    logic        hi_fix;
    logic [DW:0] step1;

    always_comb begin
        lo_fix = (a[NW-1:0] > DIGIT_MAX) || hcin;
        step1  = lo_fix ? ({1'b0, a} + {1'b0, LOW_FIX}) : {1'b0, a};
        hi_fix = (step1[DW-1:NW] > DIGIT_MAX) || cin || step1[DW];
        res    = step1[DW-1:0] + (hi_fix ? HIGH_FIX : '0);
        cy     = cin | hi_fix;
    end

endmodule

// File: rtl/alu_md_fsm.sv
`timescale 1ns/1ps
module alu_md_fsm import alu_pkg::*; #(
    parameter int DW     = 8,
    parameter int MD_LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_mul,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          busy,
    output logic          done,
    output logic          idle,
    output logic [DW-1:0] q_a,
    output logic [DW-1:0] q_b,
    output logic          q_cy,
    output logic          q_ov
);
    localparam int CW = $clog2(MD_LAT);
    localparam logic [CW-1:0] LAST = CW'(MD_LAT - 3);

    md_state_e       state, nxt;
    logic [CW-1:0]   cnt;
    logic            accept;
    logic [2*DW-1:0] prod;
    logic [DW-1:0]   quot, rem;
    logic            div0;
    logic            q_mul;

    assign accept = start && (state == MD_IDLE);

    always_comb begin
        prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
        div0 = (b == '0);
        quot = div0 ? a : a / b;
        rem  = div0 ? b : a % b;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            MD_IDLE: if (start)       nxt = MD_RUN;
            MD_RUN:  if (cnt == LAST) nxt = MD_DONE;
            MD_DONE:                  nxt = MD_IDLE;
            default:                  nxt = MD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MD_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (accept)               cnt <= '0;
            else if (state == MD_RUN) cnt <= cnt + 1'b1;
        end
    end

    // operands are resolved at acceptance; the counter only paces delivery
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_a   <= '0;
            q_b   <= '0;
            q_cy  <= 1'b0;
            q_ov  <= 1'b0;
            q_mul <= 1'b0;
        end else if (accept) begin
            q_mul <= is_mul;
            q_cy  <= 1'b0;
            if (is_mul) begin
                q_a  <= prod[DW-1:0];
                q_b  <= prod[2*DW-1:DW];
                q_ov <= (prod[2*DW-1:DW] != '0);
            end else begin
                q_a  <= quot;
                q_b  <= rem;
                q_ov <= div0;
            end
        end
    end

    // outputs
    always_comb begin
        busy = (state == MD_RUN);
        done = (state == MD_DONE);
        idle = (state == MD_IDLE);
    end

    // R12
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));
    // R12
    done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    // R12
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // R8
    mul_ov_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q_mul) |-> (q_ov == (q_b != '0)));
    // R9
    md_carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !q_cy);

endmodule

// File: rtl/byte_alu.sv
`timescale 1ns/1ps
module byte_alu import alu_pkg::*; #(
    parameter int DW     = 8,
    parameter int MD_LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [4:0]    op_code,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opd_in,
    input  logic [DW-1:0] b_in,
    input  logic          cy_in,
    input  logic          ac_in,
    input  logic          ov_in,
    output logic [DW-1:0] res_a,
    output logic [DW-1:0] res_b,
    output logic          res_b_we,
    output logic          cy_out,
    output logic          ac_out,
    output logic          ov_out,
    output logic          ne_out,
    output logic          acc_par,
    output logic          busy,
    output logic          done
);
    alu_op_e op;
    assign op = alu_op_e'(op_code);

    logic [DW-1:0] as_sum, bo_res, da_res, md_a, md_b;
    logic          as_c, as_hc, as_ov, bo_cy, da_cy, md_cy, md_ov, md_idle;
    logic          is_sub, use_cin;

    assign is_sub  = (op == OP_SUBB);
    assign use_cin = (op == OP_ADDC) || is_sub;

    alu_addsub #(.DW(DW)) u_addsub (
        .a(acc_in), .b(opd_in), .cin(use_cin & cy_in), .sub(is_sub),
        .sum(as_sum), .cout(as_c), .hcout(as_hc), .ovf(as_ov)
    );

    alu_bitops #(.DW(DW)) u_bitops (
        .op(op), .a(acc_in), .opd(opd_in), .cin(cy_in),
        .res(bo_res), .cy(bo_cy)
    );

    alu_dadj #(.DW(DW)) u_dadj (
        .a(acc_in), .cin(cy_in), .hcin(ac_in), .res(da_res), .cy(da_cy)
    );

    alu_md_fsm #(.DW(DW), .MD_LAT(MD_LAT)) u_md (
        .clk(clk), .rst_n(rst_n),
        .start(op_valid && is_multi(op)), .is_mul(op == OP_MUL),
        .a(acc_in), .b(b_in),
        .busy(busy), .done(done), .idle(md_idle),
        .q_a(md_a), .q_b(md_b), .q_cy(md_cy), .q_ov(md_ov)
    );

    assign acc_par = ^acc_in;
    assign ne_out  = (acc_in != opd_in);

    always_comb begin
        res_a    = acc_in;
        res_b    = b_in;
        res_b_we = 1'b0;
        cy_out   = cy_in;
        ac_out   = ac_in;
        ov_out   = ov_in;
        if (done) begin
            res_a    = md_a;
            res_b    = md_b;
            res_b_we = 1'b1;
            cy_out   = md_cy;
            ov_out   = md_ov;
        end else begin
            unique case (op)
                OP_ADD, OP_ADDC, OP_SUBB: begin
                    res_a  = as_sum;
                    cy_out = as_c;
                    ac_out = as_hc;
                    ov_out = as_ov;
                end
                OP_INC:  res_a = acc_in + 1'b1;
                OP_DEC:  res_a = acc_in - 1'b1;
                OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL,
                OP_RL, OP_RLC, OP_RR, OP_RRC, OP_SWAP: begin
                    res_a  = bo_res;
                    cy_out = bo_cy;
                end
                OP_DADJ: begin
                    res_a  = da_res;
                    cy_out = da_cy;
                end
                OP_CMP:  cy_out = (acc_in < opd_in);
                default: res_a = acc_in;
            endcase
        end
    end

    // R3
    incdec_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md_idle && (op == OP_INC || op == OP_DEC))
            |-> (cy_out == cy_in && ac_out == ac_in && ov_out == ov_in));
    // R5
    rlc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md_idle && op == OP_RLC) |-> (cy_out == acc_in[DW-1] && res_a[0] == cy_in));
    // R10
    cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md_idle && op == OP_CMP) |-> (res_a == acc_in && ac_out == ac_in));
    // R12
    bwe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_b_we |=> !res_b_we);

endmodule

// File: tb/tb_byte_alu.sv
`timescale 1ns/1ps
module tb_byte_alu;
    import alu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MD_LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = 5'd0;
    logic [7:0] acc_in = 8'd0, opd_in = 8'd0, b_in = 8'd0;
    logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
    logic [7:0] res_a, res_b;
    logic       res_b_we, cy_out, ac_out, ov_out, ne_out, acc_par, busy, done;

    int checks = 0;
    int errs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_alu #(.DW(8), .MD_LAT(MD_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .opd_in(opd_in), .b_in(b_in),
        .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
        .res_a(res_a), .res_b(res_b), .res_b_we(res_b_we),
        .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out),
        .ne_out(ne_out), .acc_par(acc_par), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic       cy;
        logic       ac;
        logic       ov;
    } exp_t;

    function automatic string req_of(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADDC:                 return "R1";
            OP_SUBB:                         return "R2";
            OP_INC, OP_DEC:                  return "R3";
            OP_AND, OP_OR, OP_XOR,
            OP_CLR, OP_CPL:                  return "R4";
            OP_RL, OP_RLC, OP_RR, OP_RRC:    return "R5";
            OP_SWAP:                         return "R6";
            OP_DADJ:                         return "R7";
            OP_MUL:                          return "R8";
            OP_DIV:                          return "R9";
            default:                         return "R10";
        endcase
    endfunction

    function automatic exp_t model(input alu_op_e op, input int a, input int o,
                                   input int b, input bit c, input bit ac, input bit ov);
        exp_t e;
        int v;
        e.a = a[7:0]; e.b = b[7:0]; e.cy = c; e.ac = ac; e.ov = ov;
        case (op)
            OP_ADD, OP_ADDC: begin
                v = a + o + ((op == OP_ADDC) ? int'(c) : 0);
                e.a  = v[7:0];
                e.cy = (v > 255);
                e.ac = ((a % 16) + (o % 16) + ((op == OP_ADDC) ? int'(c) : 0)) > 15;
                e.ov = (a[7] == o[7]) && (v[7] != a[7]);
            end
            OP_SUBB: begin
                v = a - o - int'(c);
                e.a  = v[7:0];
                e.cy = (v < 0);
                e.ac = (a % 16) < ((o % 16) + int'(c));
                e.ov = (a[7] != o[7]) && (v[7] != a[7]);
            end
            OP_INC:  e.a = 8'(a + 1);
            OP_DEC:  e.a = 8'(a - 1);
            OP_AND:  e.a = 8'(a & o);
            OP_OR:   e.a = 8'(a | o);
            OP_XOR:  e.a = 8'(a ^ o);
            OP_CLR:  e.a = 8'd0;
            OP_CPL:  e.a = 8'(255 - a);
            OP_RL:   e.a = 8'(((a * 2) % 256) + (a / 128));
            OP_RR:   e.a = 8'((a / 2) + (a % 2) * 128);
            OP_RLC: begin e.a = 8'(((a * 2) % 256) + int'(c)); e.cy = (a >= 128); end
            OP_RRC: begin e.a = 8'((a / 2) + int'(c) * 128); e.cy = (a % 2 == 1); end
            OP_SWAP: e.a = 8'(((a % 16) * 16) + (a / 16));
            OP_DADJ: begin
                v = a;
                if ((a % 16) > 9 || ac) v = v + 6;
                if ((((v % 256) / 16) > 9) || c || (v > 255)) begin
                    v = (v % 256) + 96;
                    e.cy = 1'b1;
                end
                e.a = 8'(v % 256);
            end
            OP_MUL: begin
                v = a * b;
                e.a = 8'(v % 256); e.b = 8'(v / 256); e.cy = 1'b0; e.ov = (v > 255);
            end
            OP_DIV: begin
                e.cy = 1'b0;
                if (b == 0) e.ov = 1'b1;
                else begin e.a = 8'(a / b); e.b = 8'(a % b); e.ov = 1'b0; end
            end
            OP_CMP: e.cy = (a < o);
            default: ;
        endcase
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run1(input alu_op_e op, input logic [7:0] a, input logic [7:0] o,
                        input logic c, input logic ac);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; acc_in = a; opd_in = o;
        cy_in = c; ac_in = ac; ov_in = $urandom_range(0, 1);
        b_in = $urandom_range(0, 255);
        #1;
        e = model(op, a, o, b_in, c, ac, ov_in);
        check({res_a, cy_out, ac_out, ov_out, res_b_we} == {e.a, e.cy, e.ac, e.ov, 1'b0},
              req_of(op), $sformatf("op %s a=%h o=%h c=%0d ac=%0d", op.name(), a, o, c, ac),
              {20'd0, res_a, cy_out, ac_out, ov_out, res_b_we},
              {20'd0, e.a, e.cy, e.ac, e.ov, 1'b0});
        if (op == OP_CMP)
            check(ne_out == (a != o), "R10", "inequality", 32'(ne_out), 32'(a != o));
        op_valid = 1'b0;
    endtask

    task automatic run_md(input alu_op_e op, input logic [7:0] a, input logic [7:0] b,
                          input bit inject);
        exp_t e;
        e = model(op, a, 0, b, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; acc_in = a; b_in = b; cy_in = 1'b1; ac_in = 1'b0;
        @(negedge clk);
        op_valid = 1'b0;
        check(busy == 1'b1, "R12", "busy after accept", 32'(busy), 32'd1);
        if (inject) begin
            op_valid = 1'b1; op_code = OP_MUL; acc_in = 8'hFF; b_in = 8'hFF;
        end
        for (int i = 0; i < MD_LAT - 2; i++) begin
            check(done == 1'b0 && res_b_we == 1'b0, "R12", "early done", 32'(done), 32'd0);
            @(negedge clk);
        end
        check(done == 1'b1 && busy == 1'b0 && res_b_we == 1'b1, "R12", "done pulse",
              {29'd0, done, busy, res_b_we}, 32'b101);
        if (op == OP_DIV && b == 0)
            check({cy_out, ov_out} == 2'b01, "R9", "divide by zero flags",
                  32'({cy_out, ov_out}), 32'b01);
        else
            check({res_a, res_b, cy_out, ov_out} == {e.a, e.b, e.cy, e.ov}, req_of(op),
                  $sformatf("%s a=%h b=%h", op.name(), a, b),
                  {14'd0, res_a, res_b, cy_out, ov_out}, {14'd0, e.a, e.b, e.cy, e.ov});
        op_valid = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R12", "back to idle", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        // R13 reset state
        check({busy, done, res_b_we} == 3'b000, "R13", "reset outputs",
              32'({busy, done, res_b_we}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, res_b_we} == 3'b000, "R13", "after reset", 32'({busy, done, res_b_we}), 32'd0);

        // directed corners
        run1(OP_ADD,  8'h7F, 8'h01, 1'b0, 1'b0);   // R1 overflow and half carry
        run1(OP_ADD,  8'hFF, 8'h01, 1'b0, 1'b0);   // R1 carry out
        run1(OP_ADDC, 8'h0F, 8'h00, 1'b1, 1'b0);   // R1
        run1(OP_SUBB, 8'h00, 8'h01, 1'b0, 1'b0);   // R2 borrow
        run1(OP_SUBB, 8'h80, 8'h00, 1'b1, 1'b0);   // R2 signed overflow
        run1(OP_INC,  8'hFF, 8'h00, 1'b1, 1'b1);   // R3 wrap
        run1(OP_DEC,  8'h00, 8'h00, 1'b0, 1'b1);   // R3 wrap
        run1(OP_CLR,  8'h5A, 8'h00, 1'b1, 1'b0);   // R4
        run1(OP_RRC,  8'h01, 8'h00, 1'b0, 1'b0);   // R5
        run1(OP_SWAP, 8'h3C, 8'h00, 1'b0, 1'b0);   // R6
        run1(OP_DADJ, 8'h9A, 8'h00, 1'b0, 1'b0);   // R7 both steps
        run1(OP_DADJ, 8'h15, 8'h00, 1'b1, 1'b0);   // R7 carry kept set
        run1(OP_CMP,  8'h42, 8'h42, 1'b1, 1'b0);   // R10 equal
        run1(OP_CMP,  8'h10, 8'hF0, 1'b0, 1'b0);   // R10 less, unsigned

        // R11 parity
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            acc_in = $urandom_range(0, 255);
            #1;
            check(acc_par == ^acc_in, "R11", "parity", 32'(acc_par), 32'(^acc_in));
        end

        // multiply / divide corners
        run_md(OP_MUL, 8'h80, 8'h02, 1'b0);        // R8 product above FF
        run_md(OP_MUL, 8'h10, 8'h0F, 1'b1);        // R8 fits, request injected while busy
        run_md(OP_DIV, 8'hFB, 8'h12, 1'b0);        // R9
        run_md(OP_DIV, 8'h33, 8'h00, 1'b1);        // R9 zero divisor

        // random single-cycle operations
        for (int i = 0; i < 400; i++) begin
            int r;
            alu_op_e op;
            r = $urandom_range(0, 16);
            op = (r == 16) ? OP_CMP : alu_op_e'(r);
            run1(op, 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        // random multiply / divide
        for (int i = 0; i < 40; i++) begin
            run_md((i % 2 == 0) ? OP_MUL : OP_DIV, 8'($urandom_range(0, 255)),
                   8'($urandom_range(0, 15) == 0 ? 0 : $urandom_range(1, 255)),
                   1'($urandom_range(0, 1)));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule